// File: doc/BRIEF.md
# Remote Cache Line Ownership Controller

This block tracks the coherence state of a single cache line on a remote node. The node belongs to a directory-based shared memory system that uses a migratory ownership protocol. The controller talks to exactly one peer, the home directory, over ordered and loss-free request and reply channels. Toward the processor it accepts access and evict requests and answers each granted access with a one-cycle grant strobe and the line data.

The line is either invalid or held exclusively with its data. Every message the node starts toward home moves the line into a waiting state, and the line leaves that state only on an answer from home. A negative answer makes the controller send the same message again on its own. One inbound slot holds an invalidate from home. The controller answers a parked invalidate unless it is about to send its own message to home; in that case it throws the invalidate away. An invalidate that arrives while the controller waits for an answer is dropped.

Top module: `remote_line_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, homeOutValid, cpuGrant and lineValid are all low.
- R2: An access request while the line is invalid puts out exactly one request message (out kind 0, data zero) in the next cycle. Nothing more is sent until home answers.
- R3: A grant from home (in kind 0) while a request is outstanding raises cpuGrant for one cycle in the next cycle. cpuData then carries the granted data and lineValid is high.
- R4: A nack from home (in kind 3) while a message is outstanding sends the same message again, with the same kind and data, in the next cycle.
- R5: An evict while the line is exclusive sends a release message (out kind 1) that carries the line data. An ack from home (in kind 2) then leaves the line invalid. When evict and access come in the same cycle, evict wins.
- R6: An invalidate from home (in kind 1) while the line is exclusive and no evict is present produces an invalidate-done message (out kind 2) with the line data, two cycles after the invalidate arrives. After that the line is invalid.
- R7: An evict while an invalidate sits in the slot discards the invalidate. Only the release message is sent, and no invalidate-done message follows.
- R8: An invalidate that arrives while the line is invalid and no access is present is answered with a nack (out kind 3, data zero) two cycles after it arrives.
- R9: An access while the line is invalid and an invalidate sits in the slot sends only the request. No nack is sent.
- R10: An invalidate that arrives while a message is outstanding is dropped. No message answers it, then or after the operation completes.
- R11: An access while the line is exclusive raises cpuGrant in the next cycle with the held data and sends no home message.
- R12: An evict while the line is invalid has no effect. Access and evict requests made while a message is outstanding have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuAccess | input | 1 | Processor wants the line |
| cpuEvict | input | 1 | Processor gives up the line |
| cpuGrant | output | 1 | One-cycle strobe: access granted |
| cpuData | output | DATA_W | Line data, valid with cpuGrant |
| lineValid | output | 1 | Line held exclusively and no message outstanding |
| homeInValid | input | 1 | Inbound home message present |
| homeInKind | input | 2 | 0 grant, 1 invalidate, 2 ack, 3 nack |
| homeInData | input | DATA_W | Data carried by a grant |
| homeOutValid | output | 1 | Outbound message present for one cycle |
| homeOutKind | output | 2 | 0 request, 1 release, 2 invalidate-done, 3 nack |
| homeOutData | output | DATA_W | Line data for release and invalidate-done, else zero |

## Verification
The checker checks on every cycle how outbound message kinds relate to line validity. A request needs a preceding access or nack, an invalidate-done only follows an exclusive line, a nack only comes from an invalid line, and every grant is traced back to its cause. The checker cannot see message data, the two-cycle delay through the slot, invalidates dropped during a wait, or the discard of a parked invalidate on evict. The bench scenarios show these, along with the evict-over-access priority, using directed sequences and random traffic compared against a reference model.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    IN_GRANT = 2'd0, IN_INV = 2'd1, IN_ACK = 2'd2, IN_NACK = 2'd3
  } inKind_e;

  typedef enum logic [KIND_W-1:0] {
    OUT_REQ = 2'd0, OUT_RELEASE = 2'd1, OUT_INVDONE = 2'd2, OUT_NACK = 2'd3
  } outKind_e;

  typedef enum logic [1:0] {
    ST_INVALID = 2'd0, ST_EXCL = 2'd1, ST_WAIT_GRANT = 2'd2, ST_WAIT_REL = 2'd3
  } lineState_e;

  typedef struct packed {
    logic     send;
    outKind_e kind;
    logic     attachLine;
    logic     clearSlot;
    logic     acceptHome;
    logic     loadLine;
    logic     grant;
  } strobes_t;
endpackage

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cpuAccess,
  input  logic                cpuEvict,
  input  logic                homeInValid,
  input  logic [KIND_W-1:0]   homeInKind,
  input  logic                slotFull,
  output strobes_t            stb,
  output logic                lineValid
);
  lineState_e state, stateNext;

  wire inGrant = homeInValid && (homeInKind == IN_GRANT);
  wire inAck   = homeInValid && (homeInKind == IN_ACK);
  wire inNack  = homeInValid && (homeInKind == IN_NACK);

  always_comb begin
    stb = '0;
    stb.kind = OUT_REQ;
    stateNext = state;
    unique case (state)
      ST_INVALID: begin
        if (cpuAccess) begin
          stb.send = 1'b1;
          stb.kind = OUT_REQ;
          stb.clearSlot = slotFull;
          stateNext = ST_WAIT_GRANT;
        end else if (slotFull) begin
          stb.send = 1'b1;
          stb.kind = OUT_NACK;
          stb.clearSlot = 1'b1;
        end else begin
          stb.acceptHome = 1'b1;
        end
      end
      ST_EXCL: begin
        if (cpuEvict) begin
          stb.send = 1'b1;
          stb.kind = OUT_RELEASE;
          stb.attachLine = 1'b1;
          stb.clearSlot = slotFull;
          stateNext = ST_WAIT_REL;
        end else if (slotFull) begin
          stb.send = 1'b1;
          stb.kind = OUT_INVDONE;
          stb.attachLine = 1'b1;
          stb.clearSlot = 1'b1;
          stateNext = ST_INVALID;
        end else begin
          stb.acceptHome = 1'b1;
          stb.grant = cpuAccess;
        end
      end
      ST_WAIT_GRANT: begin
        if (inGrant) begin
          stb.loadLine = 1'b1;
          stb.grant = 1'b1;
          stateNext = ST_EXCL;
        end else if (inNack) begin
          stb.send = 1'b1;
          stb.kind = OUT_REQ;
        end
      end
      ST_WAIT_REL: begin
        if (inAck) begin
          stateNext = ST_INVALID;
        end else if (inNack) begin
          stb.send = 1'b1;
          stb.kind = OUT_RELEASE;
          stb.attachLine = 1'b1;
        end
      end
      default: stateNext = ST_INVALID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_INVALID;
    else     state <= stateNext;
  end

  assign lineValid = (state == ST_EXCL);
endmodule

// File: rtl/rlc_datapath.sv
module rlc_datapath
  import rlc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  strobes_t            stb,
  input  logic                homeInValid,
  input  logic [KIND_W-1:0]   homeInKind,
  input  logic [DATA_W-1:0]   homeInData,
  output logic                slotFull,
  output logic                cpuGrant,
  output logic [DATA_W-1:0]   cpuData,
  output logic                homeOutValid,
  output logic [KIND_W-1:0]   homeOutKind,
  output logic [DATA_W-1:0]   homeOutData
);
  logic [DATA_W-1:0] lineData;
  wire inInv = homeInValid && (homeInKind == IN_INV);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotFull     <= 1'b0;
      lineData     <= '0;
      cpuGrant     <= 1'b0;
      homeOutValid <= 1'b0;
      homeOutKind  <= '0;
      homeOutData  <= '0;
    end else begin
      homeOutValid <= stb.send;
      homeOutKind  <= stb.send ? stb.kind : '0;
      homeOutData  <= (stb.send && stb.attachLine) ? lineData : '0;
      cpuGrant     <= stb.grant;
      if (stb.loadLine) lineData <= homeInData;
      if (stb.clearSlot) slotFull <= 1'b0;
      else if (stb.acceptHome && inInv && !slotFull) slotFull <= 1'b1;
    end
  end

  assign cpuData = lineData;
endmodule

// File: rtl/remote_line_ctrl.sv
module remote_line_ctrl
  import rlc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuAccess,
  input  logic              cpuEvict,
  output logic              cpuGrant,
  output logic [DATA_W-1:0] cpuData,
  output logic              lineValid,
  input  logic              homeInValid,
  input  logic [1:0]        homeInKind,
  input  logic [DATA_W-1:0] homeInData,
  output logic              homeOutValid,
  output logic [1:0]        homeOutKind,
  output logic [DATA_W-1:0] homeOutData
);
  strobes_t stb;
  logic     slotFull;

  rlc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cpuAccess(cpuAccess), .cpuEvict(cpuEvict),
    .homeInValid(homeInValid), .homeInKind(homeInKind), .slotFull(slotFull),
    .stb(stb), .lineValid(lineValid)
  );

  rlc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .homeInValid(homeInValid),
    .homeInKind(homeInKind), .homeInData(homeInData), .slotFull(slotFull),
    .cpuGrant(cpuGrant), .cpuData(cpuData), .homeOutValid(homeOutValid),
    .homeOutKind(homeOutKind), .homeOutData(homeOutData)
  );
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker (
  input logic       clk,
  input logic       rst,
  input logic       cpuAccess,
  input logic       cpuGrant,
  input logic       lineValid,
  input logic       homeInValid,
  input logic [1:0] homeInKind,
  input logic       homeOutValid,
  input logic [1:0] homeOutKind
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!homeOutValid && !cpuGrant && !lineValid));

  assert_req_while_waiting_R2: assert property (@(posedge clk) disable iff (rst)
    (homeOutValid && homeOutKind == 2'd0) |-> !lineValid);

  assert_grant_cause_R3: assert property (@(posedge clk) disable iff (rst)
    cpuGrant |-> (lineValid &&
      ($past(homeInValid && homeInKind == 2'd0) || $past(cpuAccess))));

  assert_req_source_R4: assert property (@(posedge clk) disable iff (rst)
    (homeOutValid && homeOutKind == 2'd0 && !$past(cpuAccess))
      |-> $past(homeInValid && homeInKind == 2'd3));

  assert_release_waits_R5: assert property (@(posedge clk) disable iff (rst)
    (homeOutValid && homeOutKind == 2'd1) |-> !lineValid);

  assert_invdone_from_excl_R6: assert property (@(posedge clk) disable iff (rst)
    (homeOutValid && homeOutKind == 2'd2) |-> (!lineValid && $past(lineValid)));

  assert_nack_from_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    (homeOutValid && homeOutKind == 2'd3) |-> (!lineValid && !$past(lineValid)));
endmodule

bind remote_line_ctrl rlc_checker u_rlc_checker (
  .clk(clk), .rst(rst), .cpuAccess(cpuAccess), .cpuGrant(cpuGrant),
  .lineValid(lineValid), .homeInValid(homeInValid), .homeInKind(homeInKind),
  .homeOutValid(homeOutValid), .homeOutKind(homeOutKind)
);

// File: tb/test_remote_line_ctrl.sv
module test_remote_line_ctrl;
  localparam int PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic cpuAccess, cpuEvict, homeInValid;
  logic [1:0] homeInKind;
  logic [DW-1:0] homeInData;
  logic cpuGrant, lineValid, homeOutValid;
  logic [DW-1:0] cpuData, homeOutData;
  logic [1:0] homeOutKind;

  int checks = 0;
  int fails = 0;

  // reference model: 0 invalid, 1 exclusive, 2 wait grant, 3 wait release
  int mState = 0;
  bit mSlot = 1'b0;
  logic [DW-1:0] mLine = '0;
  bit eOutV, eGrant;
  logic [1:0] eKind;
  logic [DW-1:0] eOutData;

  always #(PERIOD/2) clk = ~clk;

  remote_line_ctrl #(.DATA_W(DW)) i_remote_line_ctrl (
    .clk(clk), .rst(rst), .cpuAccess(cpuAccess), .cpuEvict(cpuEvict),
    .cpuGrant(cpuGrant), .cpuData(cpuData), .lineValid(lineValid),
    .homeInValid(homeInValid), .homeInKind(homeInKind), .homeInData(homeInData),
    .homeOutValid(homeOutValid), .homeOutKind(homeOutKind), .homeOutData(homeOutData)
  );

  function automatic logic [DW+DW+5:0] packObs(bit ov, logic [1:0] k, logic [DW-1:0] od,
                                              bit g, logic [DW-1:0] gd, bit lv);
    return {ov, ov ? k : 2'd0, ov ? od : '0, g, g ? gd : '0, lv};
  endfunction

  task automatic modelStep(bit acc, bit ev, bit iv, logic [1:0] ik, logic [DW-1:0] id);
    bit accept;
    bit oldSlot;
    accept = 1'b0; eOutV = 1'b0; eGrant = 1'b0; eKind = 2'd0; eOutData = '0;
    oldSlot = mSlot;
    case (mState)
      0: if (acc) begin eOutV = 1; eKind = 0; mSlot = 0; mState = 2; end
         else if (mSlot) begin eOutV = 1; eKind = 3; mSlot = 0; end
         else accept = 1;
      1: if (ev) begin eOutV = 1; eKind = 1; eOutData = mLine; mSlot = 0; mState = 3; end
         else if (mSlot) begin eOutV = 1; eKind = 2; eOutData = mLine; mSlot = 0; mState = 0; end
         else begin accept = 1; eGrant = acc; end
      2: if (iv && ik == 2'd0) begin mLine = id; eGrant = 1; mState = 1; end
         else if (iv && ik == 2'd3) begin eOutV = 1; eKind = 0; end
      default: if (iv && ik == 2'd2) mState = 0;
         else if (iv && ik == 2'd3) begin eOutV = 1; eKind = 1; eOutData = mLine; end
    endcase
    if (accept && !oldSlot && iv && ik == 2'd1) mSlot = 1;
  endtask

  task automatic step(string req, bit acc, bit ev, bit iv, logic [1:0] ik, logic [DW-1:0] id);
    logic [DW+DW+5:0] act, exp;
    cpuAccess = acc; cpuEvict = ev; homeInValid = iv; homeInKind = ik; homeInData = id;
    modelStep(acc, ev, iv, ik, id);
    @(negedge clk);
    act = packObs(homeOutValid, homeOutKind, homeOutData, cpuGrant, cpuData, lineValid);
    exp = packObs(eOutV, eKind, eOutData, eGrant, mLine, mState == 1);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; cpuAccess = 0; cpuEvict = 0; homeInValid = 0; homeInKind = 0; homeInData = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (homeOutValid !== 1'b0 || cpuGrant !== 1'b0 || lineValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual %b%b%b expected 000", homeOutValid, cpuGrant, lineValid);
    end
    rst = 1'b0;

    step("R2 request",           1, 0, 0, 0, 0);
    step("R2 single",            0, 0, 0, 0, 0);
    step("R10 inv while wait",   0, 0, 1, 1, 0);
    step("R10 no reply",         0, 0, 0, 0, 0);
    step("R12 access in wait",   1, 1, 0, 0, 0);
    step("R4 retry request",     0, 0, 1, 3, 0);
    step("R3 grant",             0, 0, 1, 0, 32'hA5A5_0001);
    step("R11 hit",              1, 0, 0, 0, 0);
    step("R6 inv parked",        0, 0, 1, 1, 0);
    step("R6 invdone",           0, 0, 0, 0, 0);
    step("R6 invalid after",     0, 0, 0, 0, 0);
    step("R2 request again",     1, 0, 0, 0, 0);
    step("R3 grant B",           0, 0, 1, 0, 32'h0BAD_F00D);
    step("R7 inv parked",        0, 0, 1, 1, 0);
    step("R7 release only",      0, 1, 0, 0, 0);
    step("R7 no invdone",        0, 0, 0, 0, 0);
    step("R4 retry release",     0, 0, 1, 3, 0);
    step("R5 ack",               0, 0, 1, 2, 0);
    step("R12 evict invalid",    0, 1, 0, 0, 0);
    step("R8 inv parked",        0, 0, 1, 1, 0);
    step("R8 nack",              0, 0, 0, 0, 0);
    step("R9 inv parked",        0, 0, 1, 1, 0);
    step("R9 request only",      1, 0, 0, 0, 0);
    step("R9 no nack",           0, 0, 0, 0, 0);
    step("R3 grant C",           0, 0, 1, 0, 32'h1234_5678);
    step("R5 evict beats access",1, 1, 0, 0, 0);
    step("R5 ack",               0, 0, 1, 2, 0);

    for (int i = 0; i < 3000; i++) begin
      bit acc, ev, iv;
      logic [1:0] ik;
      logic [DW-1:0] id;
      acc = ($urandom % 4) == 0;
      ev  = ($urandom % 6) == 0;
      iv  = ($urandom % 5) < 2;
      ik  = 2'($urandom % 4);
      id  = $urandom;
      step("R2-model random", acc, ev, iv, ik, id);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule